// File: doc/BRIEF.md
# Eight-phase symbol modulator

This block turns a stream of 16-bit samples into a phase-modulated carrier. The lowest bit of each accepted word is thrown away. The upper fifteen bits are cut into five 3-bit symbols, and the block sends them one after another. Each symbol becomes a burst of carrier at one of eight phases spaced 45 degrees apart. Every burst has the same amplitude, so the transmit power does not depend on the data.

The carrier is read from a 32-point cosine table. The table index is the symbol's phase offset plus a running tick count, and the count restarts at the start of every burst. One output sample is produced for each pulse on the enable tick. A burst lasts 64 samples, which is two full carrier periods. A whole word therefore takes 320 ticks. For the modulator to keep up with an 8 kHz sample source, the tick rate must be at least 2.56 MHz.

New words enter through a valid/ready handshake. The block refuses a new word until all five bursts of the current word have gone out.

Top module: `psk8_burst_mod`

## Requirements
- R1: After reset: `sample_o` is 0, `sample_valid_o` is 0, `busy_o` is 0, `in_ready_o` is 1 and `sym_idx_o` is 0.
- R2: A word is taken on a clock edge where `in_valid_i` and `in_ready_o` are both high. After that edge, `busy_o` is 1 and `in_ready_o` stays 0 until the word is finished. A word offered while the block is busy is held off, not lost, and is taken on the first edge where `in_ready_o` is high.
- R3: Bit 0 of `in_data_i` has no effect on any output.
- R4: Burst k (k = 0..4) carries the code in bits [15-3k : 13-3k]. The first burst takes bits [15:13] and the last takes bits [3:1].
- R5: Sample n of a burst (n = 0..63) with code c equals round(2047·cos(2π·(n + 4c)/32)). Code c is a natural binary number, and the phase rises by 45 degrees counterclockwise for each step of c; code 0 sits at phase 0.
- R6: Each burst is exactly 64 samples long (two carrier periods), and each word is exactly 320 samples long.
- R7: While busy, each cycle with `tick_i` high yields one sample. `sample_valid_o` pulses for exactly the cycle after that tick. Ticks while idle yield nothing.
- R8: `sym_idx_o` gives the index 0..4 of the burst being sent, and it only changes on a tick.
- R9: Every sample lies within ±2047.
- R10: The 320th sample and the fall of `busy_o` come out in the same cycle, and `in_ready_o` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 16 | Input sample word |
| in_valid_i | input | 1 | Input word offered |
| in_ready_o | output | 1 | Block can take a word |
| tick_i | input | 1 | Output-sample enable |
| sample_o | output | 12 | Signed carrier sample |
| sample_valid_o | output | 1 | New sample strobe |
| sym_idx_o | output | 3 | Index of the burst being sent |
| busy_o | output | 1 | Word in progress |

## Verification
The assertions assume two things about the inputs. First, `tick_i` and `in_valid_i` are synchronous and free of unknown values after reset. Second, the environment uses the handshake, so a word is never considered taken unless `in_ready_o` was high. The stimulus drives every input at the falling edge and samples the outputs at the next falling edge. It offers words only through the handshake, including one word held at the input across a whole busy period. It also toggles `tick_i` both every cycle and sparsely, so the sample timing is exercised at different tick rates.

// File: rtl/psk8_pkg.sv
package psk8_pkg;
  // carrier table points per period, as an address width
  localparam int unsigned LUT_AW = 5;
  // full-scale quarter-wave reference, 12-bit
  localparam int REF_FS = 2047;

  function automatic int quarter_ref(input int k);
    case (k)
      0: quarter_ref = 2047;
      1: quarter_ref = 2008;
      2: quarter_ref = 1891;
      3: quarter_ref = 1702;
      4: quarter_ref = 1447;
      5: quarter_ref = 1137;
      6: quarter_ref = 783;
      7: quarter_ref = 399;
      default: quarter_ref = 0;
    endcase
  endfunction
endpackage

// File: rtl/psk8_cos_rom.sv
module psk8_cos_rom
  import psk8_pkg::*;
#(
  parameter int unsigned AMP_W = 12
) (
  input  logic [LUT_AW-1:0]       idx_i,
  output logic signed [AMP_W-1:0] cos_o
);
  localparam int QSTEPS = 1 << (LUT_AW - 2);
  localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;

  logic [1:0]        quad;
  logic [LUT_AW-3:0] off;
  int                mag;
  logic              neg;

  assign quad = idx_i[LUT_AW-1:LUT_AW-2];
  assign off  = idx_i[LUT_AW-3:0];

  always_comb begin
    unique case (quad)
      2'd0:    begin mag = quarter_ref(int'(off));          neg = 1'b0; end
      2'd1:    begin mag = quarter_ref(QSTEPS - int'(off)); neg = 1'b1; end
      2'd2:    begin mag = quarter_ref(int'(off));          neg = 1'b1; end
      default: begin mag = quarter_ref(QSTEPS - int'(off)); neg = 1'b0; end
    endcase
  end

  int scaled;
  assign scaled = (mag * AMP_MAX) / REF_FS;
  assign cos_o  = AMP_W'(neg ? -scaled : scaled);
endmodule

// File: rtl/psk8_sym_slicer.sv
module psk8_sym_slicer #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned SYM_W    = 3,
  parameter int unsigned N_SYM    = 5,
  parameter int unsigned IDX_W    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [SAMPLE_W-1:0] word_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [SYM_W-1:0]    code_o
);
  localparam int unsigned PAY_W = N_SYM * SYM_W;

  logic [PAY_W-1:0] pay_q;
  logic [SYM_W-1:0] grp [N_SYM];

  // upper PAY_W bits kept, remainder (LSB) dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pay_q <= '0;
    else if (load_i) pay_q <= word_i[SAMPLE_W-1 -: PAY_W];
  end

  // group 0 is the most significant
  for (genvar g = 0; g < N_SYM; g++) begin : g_grp
    assign grp[g] = pay_q[PAY_W-1-g*SYM_W -: SYM_W];
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < N_SYM; i++)
      if (idx_i == IDX_W'(i)) code_o = grp[i];
  end
endmodule

// File: rtl/psk8_burst_ctrl.sv
module psk8_burst_ctrl #(
  parameter int unsigned N_SYM   = 5,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned TICKS   = 64,
  parameter int unsigned CNT_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             fire_o,
  output logic [IDX_W-1:0] sym_idx_o,
  output logic [CNT_W-1:0] tick_cnt_o
);
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             burst_end, word_end;

  assign fire_o    = busy_q & tick_i;
  assign burst_end = (cnt_q == CNT_W'(TICKS - 1));
  assign word_end  = burst_end & (idx_q == IDX_W'(N_SYM - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (fire_o) begin
      if (burst_end) begin
        cnt_q <= '0;
        if (word_end) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o     = busy_q;
  assign sym_idx_o  = idx_q;
  assign tick_cnt_o = cnt_q;
endmodule

// File: rtl/psk8_burst_mod.sv
module psk8_burst_mod
  import psk8_pkg::*;
#(
  parameter int unsigned SAMPLE_W       = 16,
  parameter int unsigned SYM_W          = 3,
  parameter int unsigned AMP_W          = 12,
  parameter int unsigned CYCLES_PER_SYM = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [SAMPLE_W-1:0]     in_data_i,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic                    tick_i,
  output logic signed [AMP_W-1:0] sample_o,
  output logic                    sample_valid_o,
  output logic [2:0]              sym_idx_o,
  output logic                    busy_o
);
  localparam int unsigned N_SYM = (SAMPLE_W - 1) / SYM_W;
  localparam int unsigned IDX_W = $clog2(N_SYM);
  localparam int unsigned TICKS = CYCLES_PER_SYM << LUT_AW;
  localparam int unsigned CNT_W = $clog2(TICKS);
  localparam int unsigned PH_SH = LUT_AW - SYM_W;

  logic                    start, fire, busy;
  logic [IDX_W-1:0]        idx;
  logic [CNT_W-1:0]        cnt;
  logic [SYM_W-1:0]        code;
  logic [LUT_AW-1:0]       phase;
  logic signed [AMP_W-1:0] cos_val;
  logic signed [AMP_W-1:0] sample_q;
  logic                    valid_q;

  assign in_ready_o = ~busy;
  assign start      = in_valid_i & ~busy;

  psk8_burst_ctrl #(
    .N_SYM(N_SYM), .IDX_W(IDX_W), .TICKS(TICKS), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .start_i   (start),
    .tick_i,
    .busy_o    (busy),
    .fire_o    (fire),
    .sym_idx_o (idx),
    .tick_cnt_o(cnt)
  );

  psk8_sym_slicer #(
    .SAMPLE_W(SAMPLE_W), .SYM_W(SYM_W), .N_SYM(N_SYM), .IDX_W(IDX_W)
  ) u_slice (
    .clk_i, .rst_ni,
    .load_i(start),
    .word_i(in_data_i),
    .idx_i (idx),
    .code_o(code)
  );

  // phase = code*45deg offset + ticks into burst, wraps per period
  assign phase = {code, {PH_SH{1'b0}}} + cnt[LUT_AW-1:0];

  psk8_cos_rom #(.AMP_W(AMP_W)) u_rom (
    .idx_i(phase),
    .cos_o(cos_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= fire;
      if (fire) sample_q <= cos_val;
    end
  end

  assign sample_o       = sample_q;
  assign sample_valid_o = valid_q;
  assign sym_idx_o      = 3'(idx);
  assign busy_o         = busy;
endmodule

// File: rtl/psk8_burst_mod_chk.sv
module psk8_burst_mod_chk #(
  parameter int unsigned AMP_W = 12,
  parameter int unsigned N_SYM = 5
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [15:0]             in_data_i,
  input logic                    in_valid_i,
  input logic                    in_ready_o,
  input logic                    tick_i,
  input logic signed [AMP_W-1:0] sample_o,
  input logic                    sample_valid_o,
  input logic [2:0]              sym_idx_o,
  input logic                    busy_o
);
  localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;

  // R2
  take_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (busy_o && !in_ready_o && sym_idx_o == 3'd0));

  // R7
  valid_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> $past(tick_i && busy_o));

  // R7
  idle_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !sample_valid_o);

  // R8
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_idx_o <= 3'(N_SYM - 1));

  // R8
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i && !in_valid_i) |=> $stable(sym_idx_o));

  // R9
  amp_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> (sample_o <= AMP_W'(AMP_MAX) && sample_o >= -AMP_W'(AMP_MAX)));

  // R10
  word_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (sample_valid_o && in_ready_o && $past(sym_idx_o) == 3'(N_SYM - 1)));
endmodule

bind psk8_burst_mod psk8_burst_mod_chk #(.AMP_W(AMP_W), .N_SYM(N_SYM)) u_chk (.*);

// File: tb/psk8_burst_mod_bench.sv
`timescale 1ns/1ps
module psk8_burst_mod_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        tick = 1'b0;
  logic signed [11:0] sample;
  logic        sample_valid;
  logic [2:0]  sym_idx;
  logic        busy;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  psk8_burst_mod u_psk8_burst_mod (
    .clk_i(clk), .rst_ni(rst_n),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .tick_i(tick),
    .sample_o(sample), .sample_valid_o(sample_valid),
    .sym_idx_o(sym_idx), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // reference: burst k uses bits [15-3k:13-3k]; 4 table steps per code
  function automatic int ref_sample(input logic [15:0] w, input int n);
    int k, c, ix;
    real v;
    k  = n / 64;
    c  = (w >> (13 - 3 * k)) & 7;
    ix = (n % 64 + 4 * c) % 32;
    v  = 2047.0 * $cos(2.0 * 3.14159265358979 * ix / 32.0);
    return $rtoi(v + ((v >= 0.0) ? 0.5 : -0.5));
  endfunction

  task automatic t_reset();
    chk(sample == 0,       "R1 sample", sample, 0);
    chk(sample_valid == 0, "R1 valid", sample_valid, 0);
    chk(busy == 0,         "R1 busy", busy, 0);
    chk(in_ready == 1,     "R1 ready", in_ready, 1);
    chk(sym_idx == 0,      "R1 sym_idx", sym_idx, 0);
  endtask

  task automatic t_idle_ticks();
    @(negedge clk);
    tick = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(sample_valid == 0, "R7 idle tick valid", sample_valid, 0);
      chk(busy == 0,         "R7 idle tick busy", busy, 0);
    end
    tick = 1'b0;
  endtask

  task automatic run_word(input logic [15:0] w, input int period, input bit hold_next,
                          input logic [15:0] nxt, input bit pre_taken, input string req);
    int iss = 0, got = 0, cyc = 0, guard = 0;
    bit ticked;
    if (!pre_taken) begin
      @(negedge clk);
      in_data = w; in_valid = 1'b1; tick = 1'b0;
      while (!in_ready) @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    chk(busy && !in_ready, "R2 taken", busy, 1);
    if (hold_next) in_data = nxt;
    else in_valid = 1'b0;
    while (got < 320 && guard < 330 * period + 20) begin
      ticked = ((cyc % period) == 0) && (iss < 320);
      tick = ticked;
      if (ticked) begin
        chk(sym_idx == 3'(iss / 64), "R8 sym_idx", sym_idx, iss / 64);
        iss++;
      end
      @(negedge clk);
      cyc++; guard++;
      if (ticked) begin
        chk(sample_valid == 1, "R7 strobe", sample_valid, 1);
        chk(int'(sample) == ref_sample(w, got), {req, " R4 sample"}, sample, ref_sample(w, got));
        got++;
      end else begin
        chk(sample_valid == 0, "R7 no strobe", sample_valid, 0);
      end
      if (got < 320) begin
        chk(busy == 1, "R6 still busy", busy, 1);
        if (hold_next) chk(in_ready == 0, "R2 held off", in_ready, 0);
      end
    end
    tick = 1'b0;
    chk(got == 320, "R6 sample count", got, 320);
    chk(busy == 0 && in_ready == 1, "R10 end", in_ready, 1);
    if (!hold_next) begin
      tick = 1'b1;
      repeat (2) begin
        @(negedge clk);
        chk(sample_valid == 0, "R6 no extra sample", sample_valid, 0);
      end
      tick = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_ticks();
    // codes 0..4, dense ticks (R5)
    run_word({3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 1'b1}, 1, 1'b0, 16'h0, 1'b0, "R5");
    // codes 5,6,7 sparse ticks (R5 R7)
    run_word({3'd5, 3'd6, 3'd7, 3'd0, 3'd2, 1'b0}, 3, 1'b0, 16'h0, 1'b0, "R5");
    // LSB differs only (R3)
    run_word(16'hB5A6, 1, 1'b0, 16'h0, 1'b0, "R3");
    run_word(16'hB5A7, 1, 1'b0, 16'h0, 1'b0, "R3");
    // word offered while busy is held and taken next (R2)
    run_word(16'h1234, 2, 1'b1, 16'hE9C3, 1'b0, "R2");
    run_word(16'hE9C3, 1, 1'b0, 16'h0, 1'b1, "R2");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule